// File: doc/BRIEF.md
# Flash Command Decoder with Write Buffer

This block sits between a simple synchronous bus and a behavioural model of a flash array. It reads the low byte of each bus write as a command and steps through the multi-cycle sequences for single-word programming, buffered programming of up to 32 words, and block erase. While an operation runs, a cycle counter stands in for the internal timing. The block keeps an 8-bit status register that shows ready or busy, erase suspend and sticky error flags.

Reads are combinational. They return either an array word or the status register, according to the last mode command and to whether an operation is running. A block erase can be suspended so that other blocks can be read. It is then resumed with a confirm written to any address. The array model resets to all ones. Programming ANDs the new data into the stored word. Only an erase sets a whole block back to ones.

Top module: `flash_cmd_dec`

## Requirements
- R1: After a synchronous reset `ready` is 1, the status register reads 0x80, reads return array data, and every array word reads 0xFFFF.
- R2: Command 0x70 makes reads return the status byte in bits 7:0, with bits 15:8 zero, at any address. Command 0xFF makes reads return the array word at `bus_addr`.
- R3: Command 0x40 followed by a data write programs that word at that write's address. After the program completes, reads stay in status mode until 0xFF is written.
- R4: Programming only clears bits: the stored result is the old word AND the new data.
- R5: Command 0xE8 latches the block from its address. The next write carries the word count minus one in bits 4:0 (0 to 31, so 1 to 32 words). That many data writes follow, each landing at its own address offset inside the latched block. A following 0xD0 programs all of them into the array.
- R6: A byte other than 0xD0 where the buffered-program confirm is expected sets status bits 7, 5 and 4 (status 0xB0). Nothing is programmed, and reads switch to status mode.
- R7: Command 0x20 followed by 0xD0 sets every word of the block addressed by the 0x20 write to 0xFFFF. Other blocks are unchanged. A block is 64 words, selected by `bus_addr[8:6]`.
- R8: A byte other than 0xD0 after 0x20 sets status bits 5 and 4 and erases nothing.
- R9: While an operation runs, `ready` is 0 and reads at any address return the status register with bit 7 at 0.
- R10: Command 0xB0 during a running erase pauses it. Status bits 7 and 6 become 1 and array reads of other blocks are possible. A 0xD0 written to any address resumes the erase, which then completes.
- R11: Command 0x50 clears status bits 5 and 4. No other command clears them.
- R12: While status bit 4 or 5 is set, the setup commands 0x40, 0xE8 and 0x20 are ignored.
- R13: While an operation runs, every write other than 0xB0 during an erase is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; everything samples on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Bus write strobe, one cycle per write |
| bus_addr | input | 9 | Word address for reads and writes |
| bus_wdata | input | 16 | Write data; bits 7:0 carry the command |
| bus_rdata | output | 16 | Read data: array word or status byte |
| ready | output | 1 | 1 when no program or erase is running |

## Verification
A controller stuck in a wrong sequence state shows up on the next write. Either a following command is treated as data, or the status word read one cycle later carries unexpected error bits. A lost or doubled buffer index is visible only after the copy ends, as a word in the wrong place or one left at 0xFFFF. The bench therefore reads back every buffered word, including the 32nd. A miscounting timer shows as `ready` returning too early or never. A suspend that does not freeze the erase shows as a block already blank while it is suspended.

// File: rtl/fcd_pkg.sv
`timescale 1ns/1ps
// Shared command codes and controller state type for the flash command decoder.
package fcd_pkg;
    localparam logic [7:0] CMD_READ_ARRAY  = 8'hFF;
    localparam logic [7:0] CMD_READ_STATUS = 8'h70;
    localparam logic [7:0] CMD_CLEAR_ERR   = 8'h50;
    localparam logic [7:0] CMD_WORD_PROG   = 8'h40;
    localparam logic [7:0] CMD_BUF_PROG    = 8'hE8;
    localparam logic [7:0] CMD_ERASE       = 8'h20;
    localparam logic [7:0] CMD_SUSPEND     = 8'hB0;
    localparam logic [7:0] CMD_CONFIRM     = 8'hD0;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PROG_SETUP,
        ST_BUF_COUNT,
        ST_BUF_FILL,
        ST_BUF_CONFIRM,
        ST_ERS_CONFIRM,
        ST_PROG_WAIT,
        ST_PROG_COPY,
        ST_ERS_WAIT,
        ST_ERS_SUSP
    } fcd_state_e;
endpackage

// File: rtl/fcd_timer.sv
`timescale 1ns/1ps
// Operation timer: loads a cycle count and counts down while run is high.
// Assumes load_val >= 1; done is high when the count has reached zero.
module fcd_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    // Count down the remaining busy cycles; pause when run is low.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val - 1'b1;
        else if (run && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/fcd_wbuf.sv
`timescale 1ns/1ps
// Write buffer: holds word offset and data for each queued program word.
// Assumes entries are always written before they are read; storage has no reset.
module fcd_wbuf #(
    parameter int DATA_W = 16,
    parameter int OFF_W  = 6,
    parameter int DEPTH  = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [OFF_W-1:0]  woff,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic [OFF_W-1:0]  roff,
    output logic [DATA_W-1:0] rdata
);
    logic [OFF_W-1:0]  off_mem [DEPTH];
    logic [DATA_W-1:0] dat_mem [DEPTH];

    // Store one queued word per write strobe.
    always_ff @(posedge clk) begin
        if (we) begin
            off_mem[widx] <= woff;
            dat_mem[widx] <= wdata;
        end
    end

    assign roff  = off_mem[ridx];
    assign rdata = dat_mem[ridx];
endmodule

// File: rtl/fcd_array.sv
`timescale 1ns/1ps
// Behavioural flash array: program ANDs data into one word, erase sets a block to ones.
// Assumes program and erase are never requested in the same cycle.
module fcd_array #(
    parameter int DATA_W    = 16,
    parameter int ADDR_W    = 9,
    parameter int BLK_OFF_W = 6,
    localparam int DEPTH    = 1 << ADDR_W,
    localparam int BLK_W    = ADDR_W - BLK_OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pgm_en,
    input  logic [ADDR_W-1:0] pgm_addr,
    input  logic [DATA_W-1:0] pgm_data,
    input  logic              ers_en,
    input  logic [BLK_W-1:0]  ers_blk,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] words [DEPTH];

    for (genvar w = 0; w < DEPTH; w++) begin : g_word
        logic [DATA_W-1:0] q;
        // One stored word: reset and erase to ones, program clears bits only.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= '1;
            else if (ers_en && ers_blk == BLK_W'(w >> BLK_OFF_W))
                q <= '1;
            else if (pgm_en && pgm_addr == ADDR_W'(w))
                q <= q & pgm_data;
        end
        assign words[w] = q;
    end

    assign rd_data = words[rd_addr];
endmodule

// File: rtl/fcd_ctrl.sv
`timescale 1ns/1ps
// Command sequencer: decodes bus writes, runs program/erase sequences and keeps
// the status flags. Assumes one bus write per strobe cycle and count field in bits 4:0.
module fcd_ctrl
    import fcd_pkg::*;
#(
    parameter int DATA_W       = 16,
    parameter int ADDR_W       = 9,
    parameter int BLK_OFF_W    = 6,
    parameter int BUF_WORDS    = 32,
    parameter int PROG_CYCLES  = 6,
    parameter int ERASE_CYCLES = 40,
    localparam int BLK_W       = ADDR_W - BLK_OFF_W,
    localparam int IDX_W       = $clog2(BUF_WORDS),
    localparam int MAX_CYC     = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES,
    localparam int TMR_W       = $clog2(MAX_CYC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              tmr_load,
    output logic [TMR_W-1:0]  tmr_val,
    output logic              tmr_run,
    input  logic              tmr_done,
    output logic              buf_we,
    output logic [IDX_W-1:0]  buf_widx,
    output logic [IDX_W-1:0]  buf_ridx,
    input  logic [BLK_OFF_W-1:0] buf_roff,
    input  logic [DATA_W-1:0] buf_rdata,
    output logic              pgm_en,
    output logic [ADDR_W-1:0] pgm_addr,
    output logic [DATA_W-1:0] pgm_data,
    output logic              ers_en,
    output logic [BLK_W-1:0]  ers_blk,
    output logic              busy,
    output logic              rd_status,
    output logic [7:0]        status,
    output fcd_state_e        state_o
);
    fcd_state_e       state_q;
    logic [BLK_W-1:0] blk_q;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] last_q;
    logic             err_pgm_q;
    logic             err_ers_q;
    logic             mode_status_q;
    logic [7:0]       cmd;
    logic             err_any;
    logic             is_confirm;

    assign cmd        = bus_wdata[7:0];
    assign err_any    = err_pgm_q | err_ers_q;
    assign is_confirm = (cmd == CMD_CONFIRM);

    // Sequence state, latched block/count and sticky flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= ST_IDLE;
            blk_q         <= '0;
            idx_q         <= '0;
            last_q        <= '0;
            err_pgm_q     <= 1'b0;
            err_ers_q     <= 1'b0;
            mode_status_q <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: if (bus_we) begin
                    case (cmd)
                        CMD_READ_ARRAY:  mode_status_q <= 1'b0;
                        CMD_READ_STATUS: mode_status_q <= 1'b1;
                        CMD_CLEAR_ERR: begin
                            err_pgm_q <= 1'b0;
                            err_ers_q <= 1'b0;
                        end
                        CMD_WORD_PROG: begin
                            mode_status_q <= 1'b1;
                            if (!err_any) state_q <= ST_PROG_SETUP;
                        end
                        CMD_BUF_PROG: begin
                            mode_status_q <= 1'b1;
                            if (!err_any) begin
                                blk_q   <= bus_addr[ADDR_W-1:BLK_OFF_W];
                                state_q <= ST_BUF_COUNT;
                            end
                        end
                        CMD_ERASE: begin
                            mode_status_q <= 1'b1;
                            if (!err_any) begin
                                blk_q   <= bus_addr[ADDR_W-1:BLK_OFF_W];
                                state_q <= ST_ERS_CONFIRM;
                            end
                        end
                        default: ;
                    endcase
                end
                ST_PROG_SETUP: if (bus_we) begin
                    blk_q   <= bus_addr[ADDR_W-1:BLK_OFF_W];
                    last_q  <= '0;
                    idx_q   <= '0;
                    state_q <= ST_PROG_WAIT;
                end
                ST_BUF_COUNT: if (bus_we) begin
                    last_q  <= bus_wdata[IDX_W-1:0];
                    idx_q   <= '0;
                    state_q <= ST_BUF_FILL;
                end
                ST_BUF_FILL: if (bus_we) begin
                    idx_q <= idx_q + 1'b1;
                    if (idx_q == last_q) state_q <= ST_BUF_CONFIRM;
                end
                ST_BUF_CONFIRM: if (bus_we) begin
                    idx_q <= '0;
                    if (is_confirm) begin
                        state_q <= ST_PROG_WAIT;
                    end else begin
                        err_pgm_q     <= 1'b1;
                        err_ers_q     <= 1'b1;
                        mode_status_q <= 1'b1;
                        state_q       <= ST_IDLE;
                    end
                end
                ST_ERS_CONFIRM: if (bus_we) begin
                    if (is_confirm) begin
                        state_q <= ST_ERS_WAIT;
                    end else begin
                        err_pgm_q     <= 1'b1;
                        err_ers_q     <= 1'b1;
                        mode_status_q <= 1'b1;
                        state_q       <= ST_IDLE;
                    end
                end
                ST_PROG_WAIT: if (tmr_done) begin
                    idx_q   <= '0;
                    state_q <= ST_PROG_COPY;
                end
                ST_PROG_COPY: begin
                    idx_q <= idx_q + 1'b1;
                    if (idx_q == last_q) state_q <= ST_IDLE;
                end
                ST_ERS_WAIT: begin
                    if (tmr_done)
                        state_q <= ST_IDLE;
                    else if (bus_we && cmd == CMD_SUSPEND)
                        state_q <= ST_ERS_SUSP;
                end
                ST_ERS_SUSP: if (bus_we) begin
                    case (cmd)
                        CMD_READ_ARRAY:  mode_status_q <= 1'b0;
                        CMD_READ_STATUS: mode_status_q <= 1'b1;
                        CMD_CONFIRM: begin
                            mode_status_q <= 1'b1;
                            state_q       <= ST_ERS_WAIT;
                        end
                        default: ;
                    endcase
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Timer control: load on an accepted start, count only in wait states.
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = TMR_W'(PROG_CYCLES);
        if (bus_we && state_q == ST_PROG_SETUP)
            tmr_load = 1'b1;
        if (bus_we && state_q == ST_BUF_CONFIRM && is_confirm)
            tmr_load = 1'b1;
        if (bus_we && state_q == ST_ERS_CONFIRM && is_confirm) begin
            tmr_load = 1'b1;
            tmr_val  = TMR_W'(ERASE_CYCLES);
        end
    end
    assign tmr_run = (state_q == ST_PROG_WAIT) || (state_q == ST_ERS_WAIT);

    // Buffer writes: single-word data goes to entry 0, buffered data to the running index.
    assign buf_we   = bus_we && (state_q == ST_PROG_SETUP || state_q == ST_BUF_FILL);
    assign buf_widx = (state_q == ST_BUF_FILL) ? idx_q : '0;
    assign buf_ridx = idx_q;

    // Array requests.
    assign pgm_en   = (state_q == ST_PROG_COPY);
    assign pgm_addr = {blk_q, buf_roff};
    assign pgm_data = buf_rdata;
    assign ers_en   = (state_q == ST_ERS_WAIT) && tmr_done;
    assign ers_blk  = blk_q;

    // Status view and read selection.
    assign busy      = (state_q == ST_PROG_WAIT) || (state_q == ST_PROG_COPY) ||
                       (state_q == ST_ERS_WAIT);
    assign rd_status = busy || mode_status_q;
    assign status    = {~busy, (state_q == ST_ERS_SUSP), err_ers_q, err_pgm_q, 4'b0000};
    assign state_o   = state_q;
endmodule

// File: rtl/flash_cmd_dec.sv
`timescale 1ns/1ps
// Flash command decoder top: sequencer, write buffer, timer and array model.
// Assumes a single-cycle bus write strobe; reads are combinational from bus_addr.
module flash_cmd_dec
    import fcd_pkg::*;
#(
    parameter int DATA_W       = 16,
    parameter int ADDR_W       = 9,
    parameter int BLK_OFF_W    = 6,
    parameter int BUF_WORDS    = 32,
    parameter int PROG_CYCLES  = 6,
    parameter int ERASE_CYCLES = 40,
    localparam int BLK_W       = ADDR_W - BLK_OFF_W,
    localparam int IDX_W       = $clog2(BUF_WORDS),
    localparam int MAX_CYC     = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES,
    localparam int TMR_W       = $clog2(MAX_CYC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              ready
);
    logic                 tmr_load, tmr_run, tmr_done;
    logic [TMR_W-1:0]     tmr_val;
    logic                 buf_we;
    logic [IDX_W-1:0]     buf_widx, buf_ridx;
    logic [BLK_OFF_W-1:0] buf_roff;
    logic [DATA_W-1:0]    buf_rdata;
    logic                 pgm_en, ers_en;
    logic [ADDR_W-1:0]    pgm_addr;
    logic [DATA_W-1:0]    pgm_data;
    logic [BLK_W-1:0]     ers_blk;
    logic                 busy, rd_status;
    logic [7:0]           sr;
    fcd_state_e           ctrl_state;
    logic [DATA_W-1:0]    arr_rdata;

    fcd_ctrl #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BLK_OFF_W(BLK_OFF_W),
        .BUF_WORDS(BUF_WORDS), .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .tmr_load(tmr_load), .tmr_val(tmr_val), .tmr_run(tmr_run), .tmr_done(tmr_done),
        .buf_we(buf_we), .buf_widx(buf_widx), .buf_ridx(buf_ridx),
        .buf_roff(buf_roff), .buf_rdata(buf_rdata),
        .pgm_en(pgm_en), .pgm_addr(pgm_addr), .pgm_data(pgm_data),
        .ers_en(ers_en), .ers_blk(ers_blk),
        .busy(busy), .rd_status(rd_status), .status(sr), .state_o(ctrl_state)
    );

    fcd_timer #(.CNT_W(TMR_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
        .run(tmr_run), .done(tmr_done)
    );

    fcd_wbuf #(.DATA_W(DATA_W), .OFF_W(BLK_OFF_W), .DEPTH(BUF_WORDS)) u_wbuf (
        .clk(clk), .we(buf_we), .widx(buf_widx), .woff(bus_addr[BLK_OFF_W-1:0]),
        .wdata(bus_wdata), .ridx(buf_ridx), .roff(buf_roff), .rdata(buf_rdata)
    );

    fcd_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .BLK_OFF_W(BLK_OFF_W)) u_array (
        .clk(clk), .rst_n(rst_n), .pgm_en(pgm_en), .pgm_addr(pgm_addr), .pgm_data(pgm_data),
        .ers_en(ers_en), .ers_blk(ers_blk), .rd_addr(bus_addr), .rd_data(arr_rdata)
    );

    // Read path: status byte while busy or in status mode, else the array word.
    assign bus_rdata = rd_status ? {{(DATA_W-8){1'b0}}, sr} : arr_rdata;
    assign ready     = ~busy;
endmodule

// File: rtl/fcd_checker.sv
`timescale 1ns/1ps
// Protocol checker for flash_cmd_dec, attached by bind below.
module fcd_checker
    import fcd_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              ready,
    input fcd_state_e        ctrl_state,
    input logic [7:0]        sr
);
    logic clr_cmd;
    assign clr_cmd = bus_we && ctrl_state == ST_IDLE && bus_wdata[7:0] == CMD_CLEAR_ERR;

    AST_BUSY_READS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> (bus_rdata[DATA_W-1:8] == '0 && !bus_rdata[7])); // R9
    AST_BUF_BAD_CONFIRM: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_state == ST_BUF_CONFIRM && bus_we && bus_wdata[7:0] != CMD_CONFIRM)
        |=> (sr[7] && sr[5] && sr[4])); // R6
    AST_ERS_BAD_CONFIRM: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_state == ST_ERS_CONFIRM && bus_we && bus_wdata[7:0] != CMD_CONFIRM)
        |=> (sr[5] && sr[4] && ready)); // R8
    AST_CLEAR_ERRORS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_cmd |=> (!sr[5] && !sr[4])); // R11
    AST_ERRORS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ((sr[4] || sr[5]) && !clr_cmd) |=> (sr[4] && sr[5])); // R11
    AST_SETUP_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_state == ST_IDLE && bus_we && (sr[4] || sr[5])) |=> ctrl_state == ST_IDLE); // R12
    AST_SUSPEND_FROM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sr[6]) |-> ($past(!ready) && ready && sr[7])); // R10
endmodule

bind flash_cmd_dec fcd_checker #(.DATA_W(DATA_W)) u_fcd_chk (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .ready(ready), .ctrl_state(ctrl_state), .sr(sr)
);

// File: tb/tb_flash_cmd_dec.sv
`timescale 1ns/1ps
// Self-checking bench: vector table walk, then directed corner cases.
module tb_flash_cmd_dec;
    localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_WT = 2'd2;
    localparam int NV = 56;
    // {op, requirement number, address, data or expected value}
    localparam logic [30:0] VECS [NV] = '{
        {OP_RD, 4'd1,  9'h000, 16'hFFFF}, // R1 erased after reset
        {OP_WR, 4'd2,  9'h000, 16'h0070},
        {OP_RD, 4'd2,  9'h123, 16'h0080}, // R2 status at any address
        {OP_WR, 4'd2,  9'h000, 16'h00FF},
        {OP_RD, 4'd2,  9'h005, 16'hFFFF}, // R2 back to array
        {OP_WR, 4'd3,  9'h005, 16'h0040},
        {OP_WR, 4'd3,  9'h005, 16'hF0F0},
        {OP_RD, 4'd9,  9'h1FF, 16'h0000}, // R9 busy status
        {OP_WT, 4'd3,  9'h000, 16'h0000},
        {OP_RD, 4'd3,  9'h005, 16'h0080}, // R3 stays in status mode
        {OP_WR, 4'd3,  9'h000, 16'h00FF},
        {OP_RD, 4'd3,  9'h005, 16'hF0F0}, // R3 programmed
        {OP_WR, 4'd4,  9'h005, 16'h0040},
        {OP_WR, 4'd4,  9'h005, 16'h0FFF},
        {OP_WT, 4'd4,  9'h000, 16'h0000},
        {OP_WR, 4'd4,  9'h000, 16'h00FF},
        {OP_RD, 4'd4,  9'h005, 16'h00F0}, // R4 AND of old and new
        {OP_WR, 4'd5,  9'h040, 16'h00E8},
        {OP_WR, 4'd5,  9'h040, 16'h0002},
        {OP_WR, 4'd5,  9'h041, 16'h1111},
        {OP_WR, 4'd5,  9'h042, 16'h2222},
        {OP_WR, 4'd5,  9'h050, 16'h3333},
        {OP_WR, 4'd5,  9'h040, 16'h00D0},
        {OP_WT, 4'd5,  9'h000, 16'h0000},
        {OP_WR, 4'd5,  9'h000, 16'h00FF},
        {OP_RD, 4'd5,  9'h041, 16'h1111}, // R5
        {OP_RD, 4'd5,  9'h042, 16'h2222},
        {OP_RD, 4'd5,  9'h050, 16'h3333},
        {OP_RD, 4'd5,  9'h043, 16'hFFFF},
        {OP_WR, 4'd6,  9'h080, 16'h00E8},
        {OP_WR, 4'd6,  9'h080, 16'h0000},
        {OP_WR, 4'd6,  9'h081, 16'h0000},
        {OP_WR, 4'd6,  9'h080, 16'h00AA},
        {OP_RD, 4'd6,  9'h080, 16'h00B0}, // R6 sequence error
        {OP_WR, 4'd6,  9'h000, 16'h00FF},
        {OP_RD, 4'd6,  9'h081, 16'hFFFF}, // R6 nothing programmed
        {OP_WR, 4'd12, 9'h081, 16'h0040},
        {OP_WR, 4'd12, 9'h081, 16'h1200},
        {OP_WR, 4'd12, 9'h000, 16'h00FF},
        {OP_RD, 4'd12, 9'h081, 16'hFFFF}, // R12 program refused
        {OP_WR, 4'd12, 9'h000, 16'h0070},
        {OP_RD, 4'd12, 9'h000, 16'h00B0}, // R12 flags still set
        {OP_WR, 4'd11, 9'h000, 16'h0050},
        {OP_RD, 4'd11, 9'h000, 16'h0080}, // R11 cleared
        {OP_WR, 4'd7,  9'h045, 16'h0020},
        {OP_WR, 4'd7,  9'h07F, 16'h00D0},
        {OP_WT, 4'd7,  9'h000, 16'h0000},
        {OP_WR, 4'd7,  9'h000, 16'h00FF},
        {OP_RD, 4'd7,  9'h041, 16'hFFFF}, // R7 block erased
        {OP_RD, 4'd7,  9'h005, 16'h00F0}, // R7 other block kept
        {OP_WR, 4'd8,  9'h000, 16'h0020},
        {OP_WR, 4'd8,  9'h000, 16'h00FF},
        {OP_RD, 4'd8,  9'h000, 16'h00B0}, // R8 erase sequence error
        {OP_WR, 4'd8,  9'h000, 16'h0050},
        {OP_WR, 4'd8,  9'h000, 16'h00FF},
        {OP_RD, 4'd8,  9'h005, 16'h00F0}  // R8 nothing erased
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        ready;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    flash_cmd_dec dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ready(ready)
    );

    always #10 clk = ~clk;

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [8:0] a, input logic [15:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
    endtask

    task automatic wait_ready(input string tag);
        int n = 0;
        @(negedge clk);
        while (!ready && n < 2000) begin
            @(negedge clk);
            n++;
        end
        check(tag, {15'd0, ready}, 16'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready", {15'd0, ready}, 16'd1);

        for (int i = 0; i < NV; i++) begin
            logic [30:0] v;
            string tag;
            v = VECS[i];
            tag = $sformatf("R%0d vec %0d", v[28:25], i);
            case (v[30:29])
                OP_WR:   wr(v[24:16], v[15:0]);
                OP_RD:   rd(tag, v[24:16], v[15:0]);
                default: wait_ready(tag);
            endcase
        end

        // R13: writes during a running program are ignored
        wr(9'h006, 16'h0040);
        wr(9'h006, 16'hAAAA);
        wr(9'h000, 16'h00FF);
        rd("R13 busy", 9'h006, 16'h0000);
        wait_ready("R13 done");
        rd("R13 mode kept", 9'h006, 16'h0080);
        wr(9'h000, 16'h00FF);
        rd("R3 second word", 9'h006, 16'hAAAA);

        // R10: suspend and resume an erase of block 2
        wr(9'h081, 16'h0040);
        wr(9'h081, 16'h1234);
        wait_ready("R10 setup");
        wr(9'h080, 16'h0020);
        wr(9'h080, 16'h00D0);
        check("R10 busy", {15'd0, ready}, 16'd0);
        repeat (3) @(negedge clk);
        wr(9'h000, 16'h00B0);
        rd("R10 suspended status", 9'h000, 16'h00C0);
        check("R10 ready in suspend", {15'd0, ready}, 16'd1);
        wr(9'h000, 16'h00FF);
        rd("R10 target not yet erased", 9'h081, 16'h1234);
        rd("R10 other block", 9'h005, 16'h00F0);
        wr(9'h1FF, 16'h00D0);
        rd("R10 resumed busy", 9'h000, 16'h0000);
        wait_ready("R10 finish");
        wr(9'h000, 16'h00FF);
        rd("R10 erased", 9'h081, 16'hFFFF);

        // R5: full 32-word buffer into block 3
        wr(9'h0C0, 16'h00E8);
        wr(9'h0C0, 16'h001F);
        for (int i = 0; i < 32; i++) wr(9'h0C0 + 9'(i), 16'h5A00 | 16'(i));
        wr(9'h0C0, 16'h00D0);
        wait_ready("R5 full buffer");
        wr(9'h000, 16'h00FF);
        for (int i = 0; i < 32; i++)
            rd($sformatf("R5 word %0d", i), 9'h0C0 + 9'(i), 16'h5A00 | 16'(i));
        rd("R5 past end", 9'h0E0, 16'hFFFF);

        // R1: reset in the middle of a sequence
        wr(9'h100, 16'h00E8);
        wr(9'h100, 16'h0003);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check("R1 ready after reset", {15'd0, ready}, 16'd1);
        rd("R1 array erased", 9'h0C5, 16'hFFFF);
        wr(9'h000, 16'h0070);
        rd("R1 status", 9'h000, 16'h0080);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule